// File: doc/BRIEF.md
# Three-Phase Center-Aligned PWM Generator

This block drives the six switches of a three-phase inverter bridge. A 16-bit up/down counter sweeps from zero to a programmable half-period and back once per switching period. Each of three channels compares the counter against its duty value to form a high-side window centred on the counter peak. The low side is the complement. Both sides then get a programmed dead time on their rising edges, and any pulse left shorter than a programmed minimum is dropped.

A narrow sync pulse marks the start of every period and serves as an interrupt request. Software writes a shadow copy of every setting through a simple write port. The shadow copy moves into the working registers at each period start. In double-update mode it also moves at the counter peak. A synchronous trip input, driven by external shutdown logic, silences all outputs and restarts the timing. It does not discard the shadow settings.

Top module: `pwm3_center_gen`

## Requirements
- R1: The period is 2 × H clocks, where H is the active half-period. The sync pulse rises on the first clock of each period, and successive rises are 2 × H clocks apart.
- R2: Number the clocks of a period m = 0 … 2H−1 from its start, and let Dc = min(duty, H). The raw high side is on for H−Dc ≤ m ≤ H+Dc−1. The raw low side is its complement. The phase outputs follow the raw signals one clock later.
- R3: Each output rises only after its raw signal has been on for the dead-time count plus one clocks. It falls one clock after its raw signal falls. The high and low outputs of a channel are never on together.
- R4: Define the high width as 2·Dc − dead time and the low width as 2·H − 2·Dc − dead time. A side whose width is below the minimum-width setting stays off. A width equal to the minimum is kept.
- R5: With duty ≥ H, the high side is on for the whole period and the low side stays off. With duty 0, the low side is on for the whole period and the high side stays off.
- R6: The sync output stays high for exactly the sync-width count of clocks from each period start. A sync width of 0 gives no pulse.
- R7: With mode bit 0 = 0 (single update), a shadow write takes effect only at the next period start.
- R8: With mode bit 0 = 1 (double update), a shadow write also takes effect at the counter peak, clock m = H.
- R9: The clock after `trip_rst` is sampled high, all phase outputs and sync are low. The shadow settings survive a trip. The first clock after release begins a new period with its sync pulse.
- R10: While the active half-period is 0, all phase outputs and sync remain low.
- R11: After `rst_n` is asserted, all outputs are low.
- R12: The write addresses are 0 = half-period, 1 = dead time (bits 9:0), 2 = minimum width, 3 = sync width (bits 7:0), 4 = mode (bit 0), and 5, 6, 7 = duty of channels A, B, C. Bit i of `pwm_hi` and `pwm_lo` belongs to channel i, with A = bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; one tick per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| trip_rst | input | 1 | Synchronous restart from shutdown logic |
| wr_en | input | 1 | Write strobe for the shadow settings |
| wr_addr | input | 3 | Setting select |
| wr_data | input | 16 | Write value |
| pwm_hi | output | 3 | High-side switch drives, one per channel |
| pwm_lo | output | 3 | Low-side switch drives, one per channel |
| sync_pulse | output | 1 | Period-start pulse / interrupt request |

## Verification
The bench targets the duty extremes, where an off-by-one in the compare window would show up. It uses duty 0, duty equal to H and duty above H, which expose a design that leaves a one-clock sliver or drops the full-on level. Minimum-width cases sit exactly at and just below the limit, so a strict-versus-inclusive comparison mistake flips a kept pulse into a deleted one. A duty write in the first half of a period separates single-update from double-update behaviour: a design that reloads at the wrong point shifts the pulse by half a period. A mid-run trip, followed by a restart without rewriting any setting, catches a design that clears its shadow copy or loses the first sync pulse.

// File: rtl/pwm3_pkg.sv
package pwm3_pkg;
    localparam int CW  = 16;  // counter and duty width
    localparam int DW  = 10;  // dead-time width
    localparam int SWW = 8;   // sync-width width

    localparam int ADR_HALF  = 0;
    localparam int ADR_DEAD  = 1;
    localparam int ADR_MINW  = 2;
    localparam int ADR_SYNCW = 3;
    localparam int ADR_MODE  = 4;
    localparam int ADR_DUTY0 = 5;

    typedef logic [CW-1:0] cnt_t;

    typedef struct packed {
        cnt_t           half_per;
        logic [DW-1:0]  dead;
        cnt_t           min_w;
        logic [SWW-1:0] sync_w;
        logic           dbl;
    } cfg_t;
endpackage

// File: rtl/pwm3_timebase.sv
module pwm3_timebase
    import pwm3_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           trip,
    input  cnt_t           per_act,
    input  cnt_t           per_next,
    input  logic [SWW-1:0] sync_w_next,
    input  logic           dbl,
    output cnt_t           cnt,
    output logic           up,
    output logic           load,
    output logic           sync
);
    typedef struct packed {
        cnt_t           cnt;
        logic           up;
        logic [SWW-1:0] sync_cnt;
    } tb_state_t;

    tb_state_t cur_q, nxt_d;
    logic start_d, peak_d, load_d;

    always_comb begin
        nxt_d   = cur_q;
        start_d = 1'b0;
        peak_d  = 1'b0;
        if (per_act == '0) begin
            nxt_d.cnt = '0;
            nxt_d.up  = 1'b1;
            start_d   = 1'b1;
        end else if (cur_q.up) begin
            if (cur_q.cnt >= per_act - cnt_t'(1)) begin
                nxt_d.cnt = per_act;
                nxt_d.up  = 1'b0;
                peak_d    = 1'b1;
            end else begin
                nxt_d.cnt = cur_q.cnt + cnt_t'(1);
            end
        end else begin
            if (cur_q.cnt <= cnt_t'(1)) begin
                nxt_d.cnt = '0;
                nxt_d.up  = 1'b1;
                start_d   = 1'b1;
            end else begin
                nxt_d.cnt = cur_q.cnt - cnt_t'(1);
            end
        end
        if (start_d && per_next != '0)
            nxt_d.sync_cnt = sync_w_next;
        else if (cur_q.sync_cnt != '0)
            nxt_d.sync_cnt = cur_q.sync_cnt - 1'b1;
        load_d = start_d | (peak_d & dbl);
        if (trip) begin
            nxt_d  = '{cnt: '0, up: 1'b1, sync_cnt: '0};
            load_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '{cnt: '0, up: 1'b1, sync_cnt: '0};
        else        cur_q <= nxt_d;
    end

    assign cnt  = cur_q.cnt;
    assign up   = cur_q.up;
    assign load = load_d;
    assign sync = cur_q.sync_cnt != '0;

    // R1: while climbing, the count stays strictly below the active peak
    p_up_below_peak_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.up && per_act != '0) |-> (cur_q.cnt < per_act));

    // R6: a sync pulse only begins on a clock where the count sits at zero
    p_sync_at_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync) |-> (cur_q.cnt == '0));
endmodule

// File: rtl/pwm3_leg.sv
module pwm3_leg
    import pwm3_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          trip,
    input  cnt_t          cnt,
    input  logic          up,
    input  cnt_t          per,
    input  cnt_t          duty,
    input  logic [DW-1:0] dead,
    input  cnt_t          min_w,
    output logic          out_hi,
    output logic          out_lo
);
    localparam int WW = CW + 2;

    typedef struct packed {
        logic [DW-1:0] run_hi;
        logic [DW-1:0] run_lo;
        logic          hi;
        logic          lo;
    } leg_state_t;

    leg_state_t cur_q, nxt_d;
    cnt_t dc, k;
    logic raw_hi, raw_lo, kill_hi, kill_lo;
    logic [WW-1:0] on_w, off_w, guard;

    always_comb begin
        dc      = (duty > per) ? per : duty;
        k       = up ? (per - cnt - cnt_t'(1)) : (per - cnt);
        raw_hi  = (per != '0) && (k < dc);
        raw_lo  = (per != '0) && !raw_hi;
        on_w    = {1'b0, dc, 1'b0};
        off_w   = {1'b0, per, 1'b0} - on_w;
        guard   = WW'(dead) + WW'(min_w);
        kill_hi = on_w < guard;
        kill_lo = off_w < guard;

        nxt_d.run_hi = raw_hi ? ((cur_q.run_hi >= dead) ? cur_q.run_hi
                                                        : cur_q.run_hi + 1'b1) : '0;
        nxt_d.run_lo = raw_lo ? ((cur_q.run_lo >= dead) ? cur_q.run_lo
                                                        : cur_q.run_lo + 1'b1) : '0;
        nxt_d.hi = raw_hi && (cur_q.run_hi >= dead) && !kill_hi;
        nxt_d.lo = raw_lo && (cur_q.run_lo >= dead) && !kill_lo;
        if (trip) nxt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    assign out_hi = cur_q.hi;
    assign out_lo = cur_q.lo;

    // R3: the two switches of a leg are never driven together
    p_no_shoot_through_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(cur_q.hi && cur_q.lo));

    // R2: the high output is only on when the compare window was open a clock earlier
    p_hi_needs_raw_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cur_q.hi |-> $past(raw_hi));

    // R3: with a nonzero dead time, the low side falling never coincides with the high side on
    p_dead_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dead != '0 && $fell(cur_q.lo)) |-> !cur_q.hi);
endmodule

// File: rtl/pwm3_center_gen.sv
module pwm3_center_gen
    import pwm3_pkg::*;
#(
    parameter int NCH = 3,
    localparam int AW = $clog2(ADR_DUTY0 + NCH)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           trip_rst,
    input  logic           wr_en,
    input  logic [AW-1:0]  wr_addr,
    input  logic [CW-1:0]  wr_data,
    output logic [NCH-1:0] pwm_hi,
    output logic [NCH-1:0] pwm_lo,
    output logic           sync_pulse
);
    typedef struct packed {
        cnt_t          per;
        logic [DW-1:0] dead;
        cnt_t          min_w;
    } act_t;

    typedef struct packed {
        cfg_t               sh;
        cnt_t [NCH-1:0]     sh_duty;
        act_t               act;
        cnt_t [NCH-1:0]     act_duty;
    } top_state_t;

    top_state_t cur_q, nxt_d;
    cnt_t cnt;
    logic up, load;

    always_comb begin
        nxt_d = cur_q;
        if (wr_en) begin
            case (int'(wr_addr))
                ADR_HALF:  nxt_d.sh.half_per = wr_data;
                ADR_DEAD:  nxt_d.sh.dead     = wr_data[DW-1:0];
                ADR_MINW:  nxt_d.sh.min_w    = wr_data;
                ADR_SYNCW: nxt_d.sh.sync_w   = wr_data[SWW-1:0];
                ADR_MODE:  nxt_d.sh.dbl      = wr_data[0];
                default: begin
                    for (int i = 0; i < NCH; i++)
                        if (int'(wr_addr) == ADR_DUTY0 + i) nxt_d.sh_duty[i] = wr_data;
                end
            endcase
        end
        if (trip_rst) begin
            nxt_d.act      = '0;
            nxt_d.act_duty = '0;
        end else if (load) begin
            nxt_d.act      = '{per: cur_q.sh.half_per, dead: cur_q.sh.dead,
                               min_w: cur_q.sh.min_w};
            nxt_d.act_duty = cur_q.sh_duty;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= nxt_d;
    end

    pwm3_timebase u_tb (
        .clk         (clk),
        .rst_n       (rst_n),
        .trip        (trip_rst),
        .per_act     (cur_q.act.per),
        .per_next    (cur_q.sh.half_per),
        .sync_w_next (cur_q.sh.sync_w),
        .dbl         (cur_q.sh.dbl),
        .cnt         (cnt),
        .up          (up),
        .load        (load),
        .sync        (sync_pulse)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_leg
        pwm3_leg u_leg (
            .clk    (clk),
            .rst_n  (rst_n),
            .trip   (trip_rst),
            .cnt    (cnt),
            .up     (up),
            .per    (cur_q.act.per),
            .duty   (cur_q.act_duty[g]),
            .dead   (cur_q.act.dead),
            .min_w  (cur_q.act.min_w),
            .out_hi (pwm_hi[g]),
            .out_lo (pwm_lo[g])
        );
    end

    // R9: a sampled trip leaves every output low on the following clock
    p_trip_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        trip_rst |=> (pwm_hi == '0 && pwm_lo == '0 && !sync_pulse));

    // R10: no phase drive follows a clock with a zero active half-period
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_q.act.per == '0) |=> (pwm_hi == '0 && pwm_lo == '0));
endmodule

// File: tb/pwm3_center_gen_test.sv
module pwm3_center_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       trip = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0] hi, lo;
    logic       sync;

    int checks = 0;
    int errors = 0;
    int P, DT, MW, SW, tsw;
    int d0[3];
    int d1[3];

    always #2 clk = ~clk;

    pwm3_center_gen uut (
        .clk(clk), .rst_n(rst_n), .trip_rst(trip), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data),
        .pwm_hi(hi), .pwm_lo(lo), .sync_pulse(sync)
    );

    function automatic int dact(int ch, int t);
        return (t >= tsw) ? d1[ch] : d0[ch];
    endfunction

    // R2 window: high for H-Dc <= m <= H+Dc-1
    function automatic bit hi_cond(int ch, int t);
        int m, dc;
        if (t < 0 || P == 0) return 1'b0;
        m  = t % (2 * P);
        dc = (dact(ch, t) > P) ? P : dact(ch, t);
        return (m >= P - dc) && (m <= P + dc - 1);
    endfunction

    function automatic bit lo_cond(int ch, int t);
        if (t < 0 || P == 0) return 1'b0;
        return !hi_cond(ch, t);
    endfunction

    // expected output at sample n (R2 one-clock lag, R3 dead time, R4 width filter)
    function automatic bit exp_side(int ch, int n, bit low);
        int dc, len;
        if (n < 1 || P == 0) return 1'b0;
        dc  = (dact(ch, n - 1) > P) ? P : dact(ch, n - 1);
        len = low ? (2 * P - 2 * dc - DT) : (2 * dc - DT);
        if (len < MW) return 1'b0;
        for (int j = 0; j <= DT; j++) begin
            if (low ? !lo_cond(ch, n - 1 - j) : !hi_cond(ch, n - 1 - j)) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic bit exp_sync(int n);
        if (P == 0) return 1'b0;
        return (n % (2 * P)) < SW;
    endfunction

    task automatic check(bit ok, string tag, string what, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    task automatic wr(int a, int d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(a); wr_data = 16'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // R12 address map; returns at sample point n = 0 of a fresh period
    task automatic start_run(int p, int dt, int mw, int sw, int mode,
                             int da, int db, int dcc);
        @(negedge clk);
        trip = 1'b1;
        wr(0, p); wr(1, dt); wr(2, mw); wr(3, sw); wr(4, mode);
        wr(5, da); wr(6, db); wr(7, dcc);
        trip = 1'b0;
        @(negedge clk);
        P = p; DT = dt; MW = mw; SW = sw;
        d0[0] = da; d0[1] = db; d0[2] = dcc;
        d1 = d0;
        tsw = 1 << 30;
    endtask

    task automatic run_window(int N, string thi, string tlo, string tsy,
                              int w, int wa, int wd);
        int bh = 0, bl = 0, bs = 0;
        int ah = 0, eh = 0, al = 0, el = 0, as_ = 0, es = 0;
        int nh = -1, nl = -1, ns = -1;
        for (int n = 0; n < N; n++) begin
            logic [2:0] xh, xl;
            logic xs;
            for (int c = 0; c < 3; c++) begin
                xh[c] = exp_side(c, n, 1'b0);
                xl[c] = exp_side(c, n, 1'b1);
            end
            xs = exp_sync(n);
            if (hi !== xh && bh == 0) begin bh = 1; ah = int'(hi); eh = int'(xh); nh = n; end
            if (lo !== xl && bl == 0) begin bl = 1; al = int'(lo); el = int'(xl); nl = n; end
            if (sync !== xs && bs == 0) begin bs = 1; as_ = int'(sync); es = int'(xs); ns = n; end
            if (w >= 1 && n == w - 1) begin
                wr_en = 1'b1; wr_addr = 3'(wa); wr_data = 16'(wd);
            end
            if (n == w) wr_en = 1'b0;
            @(negedge clk);
        end
        check(bh == 0, thi, $sformatf("high side at cycle %0d", nh), ah, eh);
        check(bl == 0, tlo, $sformatf("low side at cycle %0d", nl), al, el);
        check(bs == 0, tsy, $sformatf("sync at cycle %0d", ns), as_, es);
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(hi == 3'b000, "R11", "high after reset", int'(hi), 0);
        check(lo == 3'b000, "R11", "low after reset", int'(lo), 0);
        check(sync == 1'b0, "R11", "sync after reset", int'(sync), 0);
    endtask

    task automatic t_idle();
        start_run(0, 1, 0, 4, 0, 5, 5, 5);
        run_window(20, "R10", "R10", "R10", -1, 0, 0);
    endtask

    task automatic t_basic();
        start_run(10, 2, 0, 3, 0, 3, 7, 0);
        run_window(60, "R2", "R3", "R1", -1, 0, 0);
    endtask

    task automatic t_extremes();
        start_run(6, 1, 0, 0, 0, 6, 9, 0);
        run_window(36, "R5", "R5", "R6", -1, 0, 0);
    endtask

    task automatic t_min_width();
        // A: high width 4 == minimum kept; B: width 2 dropped; C: low width 2 dropped
        start_run(12, 2, 4, 12, 0, 3, 2, 10);
        run_window(72, "R4", "R4", "R6", -1, 0, 0);
    endtask

    task automatic t_single_update();
        start_run(8, 0, 0, 2, 0, 2, 2, 2);
        d1[0] = 6; tsw = 16;
        run_window(48, "R7", "R7", "R1", 2, 5, 6);
    endtask

    task automatic t_double_update();
        start_run(8, 0, 0, 2, 1, 2, 2, 2);
        d1[0] = 6; tsw = 8;
        run_window(48, "R8", "R8", "R1", 2, 5, 6);
    endtask

    task automatic t_trip();
        start_run(5, 1, 0, 3, 0, 2, 4, 5);
        run_window(7, "R2", "R3", "R1", -1, 0, 0);
        trip = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 3; i++) begin
            check(hi == 3'b000 && lo == 3'b000 && sync == 1'b0, "R9",
                  "outputs during trip", int'({hi, lo, sync}), 0);
            @(negedge clk);
        end
        trip = 1'b0;
        @(negedge clk);
        run_window(30, "R9", "R9", "R9", -1, 0, 0);
    endtask

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog R1: actual hung expected finished");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_idle();
        t_basic();
        t_extremes();
        t_min_width();
        t_single_update();
        t_double_update();
        t_trip();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule